// File: doc/BRIEF.md
# Interprocessor Mailbox Register Bank

This block lets two processors, called side A and side B, pass short messages to each other. It holds four mailboxes, and each mailbox has two 16-bit words. Mailboxes 0 and 1 belong to side A: only side A can write them, and side B is the receiver. Mailboxes 2 and 3 belong to side B: only side B can write them, and side A is the receiver. Each side reaches the whole bank through its own simple register port, which has an address, a write strobe, a read strobe, write data and read data.

When the owning side writes either word of a mailbox, the block raises a level interrupt toward the receiving side. The interrupt stays high until the receiver reads either word of that mailbox. A write from the side that does not own the mailbox is dropped. A read by the owning side leaves the interrupt alone. Software uses the interrupt as a "message waiting" flag. The read that collects the message also acknowledges it.

Top module: `mbox_bank`

## Requirements
- R1: After reset, all eight data words read as zero from both ports, and all four interrupt outputs are low.
- R2: The word address is mailbox*2 + word. Addresses 0 to 3 are mailboxes 0 and 1, which port A owns. Addresses 4 to 7 are mailboxes 2 and 3, which port B owns. An owner write stores its data at the next clock edge.
- R3: Either port can read any address. Its read data shows the addressed word in the same cycle while its read strobe is high, and is zero while the read strobe is low.
- R4: A write to a mailbox from the side that does not own it changes neither the stored data nor any interrupt.
- R5: An owner write to either word of a mailbox sets that mailbox's interrupt from the next clock edge. The interrupt then stays high at a level.
- R6: A receiver read of either word of a mailbox clears that mailbox's interrupt at the next clock edge.
- R7: A read by the owning side does not clear its own mailbox's interrupt.
- R8: If an owner write and a receiver read of the same mailbox happen in the same cycle, the interrupt is set, or stays set, after that edge.
- R9: Interrupt routing is fixed. irqToB[i] belongs to mailbox i, and irqToA[i] belongs to mailbox 2+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnA | input | 1 | Port A write strobe |
| rdEnA | input | 1 | Port A read strobe |
| addrA | input | 3 | Port A word address |
| wrDataA | input | 16 | Port A write data |
| rdDataA | output | 16 | Port A read data |
| wrEnB | input | 1 | Port B write strobe |
| rdEnB | input | 1 | Port B read strobe |
| addrB | input | 3 | Port B word address |
| wrDataB | input | 16 | Port B write data |
| rdDataB | output | 16 | Port B read data |
| irqToA | output | 2 | Interrupts toward side A, for mailboxes 2 and 3 |
| irqToB | output | 2 | Interrupts toward side B, for mailboxes 0 and 1 |

## Verification
The assertions check the interrupt rules on every cycle, for every mailbox:
- an owner write sets the interrupt on the next edge;
- a receiver read with no write in the same cycle clears it;
- an interrupt stays high when there is no receiver read;
- an interrupt rises only after an owner write, so a non-owner write can never set one.

The data side can only be shown by the bench's scenarios, because it needs a model of the stored contents. These scenarios cover stored words, dropped non-owner writes observed through a later read, reset contents, and the write-versus-read collision.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_BOXES  = 4;
  localparam int MB_WORDS  = 2;
  localparam int MB_SLOTS  = MB_BOXES * MB_WORDS;
  localparam int MB_ADDR_W = $clog2(MB_SLOTS);
  localparam int MB_WSEL_W = $clog2(MB_WORDS);
  localparam int MB_BOX_W  = MB_ADDR_W - MB_WSEL_W;
  localparam int MB_HALF   = MB_BOXES / 2;

  // Strobes from control to datapath: one write enable per stored word.
  typedef struct packed {
    logic [MB_SLOTS-1:0] wrSlot;
  } mbStrobe_t;

  // The lower half of the mailboxes belongs to side A, the upper half to side B.
  function automatic bit boxOwnedByB(int box);
    return box >= MB_HALF;
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEnA,
  input  logic                 rdEnA,
  input  logic [MB_ADDR_W-1:0] addrA,
  input  logic                 wrEnB,
  input  logic                 rdEnB,
  input  logic [MB_ADDR_W-1:0] addrB,
  output mbStrobe_t            strobe,
  output logic [MB_BOXES-1:0]  irqFlag
);
  logic [MB_BOX_W-1:0] boxA, boxB;
  logic [MB_BOXES-1:0] boxWritten, rxRead;

  assign boxA = addrA[MB_ADDR_W-1:MB_WSEL_W];
  assign boxB = addrB[MB_ADDR_W-1:MB_WSEL_W];

  for (genvar s = 0; s < MB_SLOTS; s++) begin : gSlot
    localparam bit OWN_B = boxOwnedByB(s / MB_WORDS);
    if (OWN_B) begin : gB
      assign strobe.wrSlot[s] = wrEnB && (addrB == MB_ADDR_W'(s));
    end else begin : gA
      assign strobe.wrSlot[s] = wrEnA && (addrA == MB_ADDR_W'(s));
    end
  end

  for (genvar b = 0; b < MB_BOXES; b++) begin : gBox
    localparam bit OWN_B = boxOwnedByB(b);
    assign boxWritten[b] = |strobe.wrSlot[b*MB_WORDS +: MB_WORDS];
    if (OWN_B) begin : gRxA
      assign rxRead[b] = rdEnA && (boxA == MB_BOX_W'(b));
    end else begin : gRxB
      assign rxRead[b] = rdEnB && (boxB == MB_BOX_W'(b));
    end

    // A write in the same cycle takes priority over the receiver's acknowledge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              irqFlag[b] <= 1'b0;
      else if (boxWritten[b]) irqFlag[b] <= 1'b1;
      else if (rxRead[b])     irqFlag[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mbStrobe_t            strobe,
  input  logic [DATA_W-1:0]    wrDataA,
  input  logic [DATA_W-1:0]    wrDataB,
  input  logic                 rdEnA,
  input  logic [MB_ADDR_W-1:0] addrA,
  input  logic                 rdEnB,
  input  logic [MB_ADDR_W-1:0] addrB,
  output logic [DATA_W-1:0]    rdDataA,
  output logic [DATA_W-1:0]    rdDataB
);
  logic [DATA_W-1:0] store [MB_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < MB_SLOTS; s++) store[s] <= '0;
    end else begin
      for (int s = 0; s < MB_SLOTS; s++) begin
        if (strobe.wrSlot[s])
          store[s] <= boxOwnedByB(s / MB_WORDS) ? wrDataB : wrDataA;
      end
    end
  end

  assign rdDataA = rdEnA ? store[addrA] : '0;
  assign rdDataB = rdEnB ? store[addrB] : '0;
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEnA,
  input  logic                 rdEnA,
  input  logic [MB_ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0]    wrDataA,
  output logic [DATA_W-1:0]    rdDataA,
  input  logic                 wrEnB,
  input  logic                 rdEnB,
  input  logic [MB_ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0]    wrDataB,
  output logic [DATA_W-1:0]    rdDataB,
  output logic [MB_HALF-1:0]   irqToA,
  output logic [MB_HALF-1:0]   irqToB
);
  mbStrobe_t           strobe;
  logic [MB_BOXES-1:0] irqFlag;

  mbox_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEnA(wrEnA), .rdEnA(rdEnA), .addrA(addrA),
    .wrEnB(wrEnB), .rdEnB(rdEnB), .addrB(addrB),
    .strobe(strobe), .irqFlag(irqFlag)
  );

  mbox_data #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrDataA(wrDataA), .wrDataB(wrDataB),
    .rdEnA(rdEnA), .addrA(addrA), .rdEnB(rdEnB), .addrB(addrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  // Side B receives from the A-owned lower half; side A receives from the upper half.
  assign irqToB = irqFlag[MB_HALF-1:0];
  assign irqToA = irqFlag[MB_BOXES-1:MB_HALF];
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEnA,
  input logic                 rdEnA,
  input logic [MB_ADDR_W-1:0] addrA,
  input logic [DATA_W-1:0]    rdDataA,
  input logic                 wrEnB,
  input logic                 rdEnB,
  input logic [MB_ADDR_W-1:0] addrB,
  input logic [DATA_W-1:0]    rdDataB,
  input logic [MB_HALF-1:0]   irqToA,
  input logic [MB_HALF-1:0]   irqToB
);
  logic [MB_BOX_W-1:0] boxA, boxB;
  assign boxA = addrA[MB_ADDR_W-1:MB_WSEL_W];
  assign boxB = addrB[MB_ADDR_W-1:MB_WSEL_W];

  for (genvar i = 0; i < MB_HALF; i++) begin : gChk
    // Mailbox i: A writes, B receives (R5, R9)
    assert_irqb_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEnA && boxA == MB_BOX_W'(i)) |=> irqToB[i]);
    // Mailbox HALF+i: B writes, A receives (R5, R9)
    assert_irqa_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEnB && boxB == MB_BOX_W'(MB_HALF + i)) |=> irqToA[i]);
    assert_irqb_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
      (rdEnB && boxB == MB_BOX_W'(i) && !(wrEnA && boxA == MB_BOX_W'(i))) |=> !irqToB[i]);
    assert_irqa_clr_R6: assert property (@(posedge clk) disable iff (!rstN)
      (rdEnA && boxA == MB_BOX_W'(MB_HALF + i) &&
       !(wrEnB && boxB == MB_BOX_W'(MB_HALF + i))) |=> !irqToA[i]);
    assert_irqb_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (irqToB[i] && !(rdEnB && boxB == MB_BOX_W'(i))) |=> irqToB[i]);
    assert_irqa_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (irqToA[i] && !(rdEnA && boxA == MB_BOX_W'(MB_HALF + i))) |=> irqToA[i]);
    assert_irqb_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqToB[i]) |-> $past(wrEnA && boxA == MB_BOX_W'(i)));
    assert_irqa_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqToA[i]) |-> $past(wrEnB && boxB == MB_BOX_W'(MB_HALF + i)));
  end

  assert_idle_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEnA |-> rdDataA == '0) and (!rdEnB |-> rdDataB == '0));
endmodule

bind mbox_bank mbox_bank_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN),
  .wrEnA(wrEnA), .rdEnA(rdEnA), .addrA(addrA), .rdDataA(rdDataA),
  .wrEnB(wrEnB), .rdEnB(rdEnB), .addrB(addrB), .rdDataB(rdDataB),
  .irqToA(irqToA), .irqToB(irqToB)
);

// File: tb/sim_mbox_bank.sv
`timescale 1ns/1ps
module sim_mbox_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnA = 0, rdEnA = 0, wrEnB = 0, rdEnB = 0;
  logic [2:0]  addrA = 0, addrB = 0;
  logic [15:0] wrDataA = 0, wrDataB = 0;
  logic [15:0] rdDataA, rdDataB;
  logic [1:0]  irqToA, irqToB;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [15:0] model [8];
  logic [3:0]  irqModel;

  always #2 clk = ~clk;

  mbox_bank u0 (
    .clk(clk), .rstN(rstN),
    .wrEnA(wrEnA), .rdEnA(rdEnA), .addrA(addrA), .wrDataA(wrDataA), .rdDataA(rdDataA),
    .wrEnB(wrEnB), .rdEnB(rdEnB), .addrB(addrB), .wrDataB(wrDataB), .rdDataB(rdDataB),
    .irqToA(irqToA), .irqToB(irqToB)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(logic en, logic [2:0] a);
    return en ? model[a] : 16'h0;
  endfunction

  // Drive one cycle at the falling edge, check reads, update model, check irqs after the edge.
  task automatic step(logic wa, logic [2:0] aa, logic [15:0] da, logic ra,
                      logic wb, logic [2:0] ab, logic [15:0] db, logic rb, string tag);
    logic [3:0] setM, clrM;
    wrEnA = wa; addrA = aa; wrDataA = da; rdEnA = ra;
    wrEnB = wb; addrB = ab; wrDataB = db; rdEnB = rb;
    #1;
    check({tag, " R3 read A"}, rdDataA, expRead(ra, aa));
    check({tag, " R3 read B"}, rdDataB, expRead(rb, ab));
    setM = 0; clrM = 0;
    if (wa && aa < 4) begin model[aa] = da; setM[aa >> 1] = 1; end
    if (wb && ab >= 4) begin model[ab] = db; setM[ab >> 1] = 1; end
    if (ra && aa >= 4) clrM[aa >> 1] = 1;
    if (rb && ab < 4)  clrM[ab >> 1] = 1;
    irqModel = (irqModel & ~clrM) | setM;
    @(negedge clk);
    check({tag, " R9 irqToB"}, {14'h0, irqToB}, {14'h0, irqModel[1:0]});
    check({tag, " R9 irqToA"}, {14'h0, irqToA}, {14'h0, irqModel[3:2]});
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) model[i] = 16'h0;
    irqModel = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset contents and interrupts
    check("R1 irqToA", {14'h0, irqToA}, 16'h0);
    check("R1 irqToB", {14'h0, irqToB}, 16'h0);
    for (int a = 0; a < 8; a++) step(0, 3'(a), 0, 1, 0, 3'(a), 0, 1, "R1");

    // R2, R5: A writes mailbox 0 word 1
    step(1, 3'd1, 16'hBEEF, 0, 0, 0, 0, 0, "R2 R5");
    // R7: the writer reads its own mailbox, the interrupt stays
    step(0, 3'd1, 0, 1, 0, 0, 0, 0, "R7");
    check("R7 irqToB[0] held", {15'h0, irqToB[0]}, 16'h1);
    // R4: B writes A-owned word, then reads it (this read also clears, R6)
    step(0, 0, 0, 0, 1, 3'd1, 16'h1111, 0, "R4");
    step(0, 0, 0, 0, 0, 3'd1, 0, 1, "R4 R6");
    check("R6 irqToB[0] cleared", {15'h0, irqToB[0]}, 16'h0);
    // R4: A writes B-owned word; no data, no interrupt
    step(1, 3'd6, 16'h2222, 0, 0, 0, 0, 0, "R4");
    check("R4 irqToA untouched", {14'h0, irqToA}, 16'h0);
    step(1, 3'd0, 16'h0, 1, 0, 3'd6, 0, 1, "R4 readback");
    step(0, 0, 0, 0, 0, 3'd0, 0, 1, "R6");
    // R9, R5: B writes mailbox 2
    step(0, 0, 0, 0, 1, 3'd5, 16'hCAFE, 0, "R9 R5");
    check("R9 irqToA[0] for mailbox 2", {15'h0, irqToA[0]}, 16'h1);
    // R8: B writes again while A reads the same mailbox
    step(0, 3'd5, 0, 1, 1, 3'd4, 16'h0F0F, 0, "R8");
    check("R8 irqToA[0] kept", {15'h0, irqToA[0]}, 16'h1);
    // R6: receiver read of the other word clears
    step(0, 3'd4, 0, 1, 0, 0, 0, 0, "R6");
    check("R6 irqToA[0] cleared", {15'h0, irqToA[0]}, 16'h0);
    idle("R6 idle");

    // Random traffic: R2 R3 R4 R5 R6 R7 R8 checked against the model
    for (int n = 0; n < 4000; n++) begin
      logic wa, ra, wb, rb;
      wa = ($urandom % 3) == 0; ra = ($urandom % 2) == 0;
      wb = ($urandom % 3) == 0; rb = ($urandom % 2) == 0;
      step(wa, 3'($urandom), 16'($urandom), ra, wb, 3'($urandom), 16'($urandom), rb,
           "R2 R5 R6 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule